// File: doc/BRIEF.md
# Interleaved Cache Bank Request Router

This block sits between the load/store issue ports of a core and a set of single-ported cache banks. Every cycle each issue port may present one request, given as a valid bit and a byte address. The block drops the byte-offset bits of the address and uses the low bits of the remaining line address to pick a bank. Consecutive cache lines therefore fall in consecutive banks.

Requests that pick different banks are all accepted in the same cycle. When several valid requests pick the same bank, the lowest-numbered port is accepted. Every other port in that group is told in the same cycle that it hit a bank conflict, so that the scheduler can replay it. Each accepted request drives its bank's enable and row index one clock later. The bank count must be a power of two, so the modulo is a plain bit slice.

Top module: `bank_router`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, every bank enable is 0.
- R2: The bank chosen for a request is address bits [OFF_W+BANK_W-1:OFF_W], where OFF_W = log2(LINE_BYTES) and BANK_W = log2(NBANKS). With the defaults (64-byte lines, 4 banks) these are bits [7:6].
- R3: The row index sent to the chosen bank is the address shifted right by OFF_W+BANK_W, which is bits [31:8] with the defaults. It is placed in slice [b*IDX_W +: IDX_W] of bank_idx for bank b.
- R4: In the cycle a request is presented, every valid request whose bank is not used by any lower-numbered valid port gets accept=1 and conflict=0.
- R5: When valid requests share a bank, the lowest-numbered of them is accepted. Each of the others gets conflict=1 and accept=0 in that same cycle.
- R6: Two requests to the same cache line are handled as a bank conflict under R5. They are not merged.
- R7: A port whose valid bit is 0 gets accept=0 and conflict=0. It claims no bank. If no port is valid, every bank enable is 0 on the next cycle.
- R8: An accepted request sets bank_en[b] and the index of its bank exactly one clock after it is presented. A bank that receives no accepted request has bank_en[b]=0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NPORTS | Request present, one bit per port |
| req_addr | input | NPORTS*ADDR_W | Byte address per port; port p is slice [p*ADDR_W +: ADDR_W] |
| req_accept | output | NPORTS | Request won its bank this cycle |
| req_conflict | output | NPORTS | Request lost a same-bank collision; must be replayed |
| bank_en | output | NBANKS | Registered enable, one bit per bank |
| bank_idx | output | NBANKS*IDX_W | Registered row index, one slice per bank |

## Verification
The conflict decision is combinational, so a wrong bank slice or a wrong priority shows on accept and conflict in the very cycle the request is presented. The bench compares these against its model before the next clock edge. An error in the grant register shows one clock later, as a bank enabled with no winner, or a winner whose bank stays idle, or a wrong row index. The bench uses directed same-bank, same-line and idle patterns, and then runs a long stretch of random addresses limited to a few lines so that collisions are frequent.

// File: rtl/bank_router.sv
module bank_router #(
  parameter int NPORTS     = 2,
  parameter int NBANKS     = 4,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int BANK_W = $clog2(NBANKS),
  localparam int IDX_W  = ADDR_W - OFF_W - BANK_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS-1:0]        req_valid,
  input  logic [NPORTS*ADDR_W-1:0] req_addr,
  output logic [NPORTS-1:0]        req_accept,
  output logic [NPORTS-1:0]        req_conflict,
  output logic [NBANKS-1:0]        bank_en,
  output logic [NBANKS*IDX_W-1:0]  bank_idx
);

  logic [BANK_W-1:0] sel [NPORTS];
  logic [IDX_W-1:0]  row [NPORTS];
  logic [NBANKS-1:0]       en_d;
  logic [NBANKS*IDX_W-1:0] idx_d;

  for (genvar p = 0; p < NPORTS; p++) begin : g_slice
    assign sel[p] = req_addr[p*ADDR_W+OFF_W +: BANK_W];
    assign row[p] = req_addr[p*ADDR_W+OFF_W+BANK_W +: IDX_W];
  end

  always_comb begin
    req_conflict = '0;
    for (int p = 1; p < NPORTS; p++)
      for (int q = 0; q < p; q++)
        if (req_valid[p] && req_valid[q] && sel[p] == sel[q])
          req_conflict[p] = 1'b1;
  end

  assign req_accept = req_valid & ~req_conflict;

  always_comb begin
    en_d  = '0;
    idx_d = bank_idx;
    for (int p = 0; p < NPORTS; p++)
      if (req_accept[p]) begin
        en_d[sel[p]] = 1'b1;
        idx_d[sel[p]*IDX_W +: IDX_W] = row[p];
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bank_en  <= '0;
      bank_idx <= '0;
    end else begin
      bank_en  <= en_d;
      bank_idx <= idx_d;
    end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> bank_en == '0); // R1

  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid == '0 |=> bank_en == '0); // R7

  AST_GRANT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(bank_en) == $past($countones(req_accept))); // R8

  for (genvar p = 1; p < NPORTS; p++) begin : g_ast
    AST_LOSER_HAS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      req_conflict[p] |-> (req_accept[p-1:0] != '0)); // R5
  end

endmodule

// File: tb/bank_router_bench.sv
module bank_router_bench;
  localparam int NP = 2, NB = 4, AW = 32, IW = 24;

  logic clk = 0, rst_n = 0;
  logic [NP-1:0]    vld = '0;
  logic [NP*AW-1:0] addr = '0;
  logic [NP-1:0]    acc, conf;
  logic [NB-1:0]    ben;
  logic [NB*IW-1:0] bidx;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  bank_router u_bank_router (
    .clk(clk), .rst_n(rst_n), .req_valid(vld), .req_addr(addr),
    .req_accept(acc), .req_conflict(conf), .bank_en(ben), .bank_idx(bidx)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [NP-1:0] v, input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                      input string tag);
    logic [AW-1:0] a [NP];
    logic [NP-1:0] eacc, econf;
    logic [NB-1:0] een;
    logic [IW-1:0] eidx [NB];
    a[0] = a0; a[1] = a1;
    eacc = '0; econf = '0; een = '0;
    for (int b = 0; b < NB; b++) eidx[b] = '0;
    @(negedge clk);
    vld = v; addr = {a1, a0};
    for (int p = 0; p < NP; p++) begin
      int bk = (a[p] / 64) % NB;
      if (v[p]) begin
        if (een[bk]) econf[p] = 1'b1;
        else begin
          eacc[p] = 1'b1; een[bk] = 1'b1; eidx[bk] = IW'(a[p] / 256);
        end
      end
    end
    #1;
    chk(tag, "accept", acc, eacc);
    chk(tag, "conflict", conf, econf);
    @(posedge clk); #1;
    chk(tag, "bank_en", ben, een);
    for (int b = 0; b < NB; b++)
      if (een[b]) chk(tag, "bank_idx", bidx[b*IW +: IW], eidx[b]);
  endtask

  initial begin
    #(8*100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "bank_en in reset", ben, 0);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R1", "bank_en after release", ben, 0);
    step(2'b01, 32'h0000_0040, 32'h0, "R2");
    step(2'b01, 32'h1234_56C7, 32'h0, "R3");
    step(2'b11, 32'h0000_0000, 32'h0000_0080, "R4");
    step(2'b11, 32'hABCD_00C0, 32'h1111_1140, "R4");
    step(2'b11, 32'h0000_0040, 32'h0000_0140, "R5");
    step(2'b11, 32'h0000_0F80, 32'hFFFF_FF80, "R5");
    step(2'b11, 32'h0000_1000, 32'h0000_1008, "R6");
    step(2'b10, 32'h0000_0040, 32'h0000_0040, "R7");
    step(2'b00, 32'h0000_0040, 32'h0000_0040, "R7");
    chk("R7", "no accept when idle", acc, 0);
    step(2'b10, 32'h0, 32'h7777_7700, "R8");
    step(2'b00, 32'h0, 32'h0, "R8");
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] r0, r1;
      r0 = {$urandom} & 32'h0000_03FF;
      r1 = {$urandom} & 32'h0000_03FF;
      step(2'($urandom), r0, r1, "R5");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule